// File: doc/BRIEF.md
# Synthesizable Fault Insertion Cell

This block is a small wrapper placed on a chosen net or register of a design under test so that faults can be switched on while the design runs. A single control input, the fault enable, turns the fault on. When it is low the wrapper passes its input through untouched. When it is high, every bit named in a per-bit select mask is corrupted according to the fault model chosen at elaboration time. The timing of the fault enable (when it rises and for how long it stays high) comes from an external scheduler and is not part of this block.

Four fault models are offered, chosen by a 2-bit model parameter. Model 00 is stuck-at-0 and model 01 is stuck-at-1. Model 10 is a transient substitute, which drives a parameter-given value onto the selected bits for as long as the enable is held. These three are purely combinational: one gating level sits on the net and adds no latency. Model 11 is an upset (bit-flip) model. It wraps the register itself and places a multiplexer in front of its data input. While the enable and a bit's select are both 1, the corrupted data input is loaded at the next clock edge. A direction parameter picks how the corruption is made: a plain inversion, flip-to-0 or flip-to-1. The wrapped register has a synchronous active-high reset that clears it, and this reset wins over any fault.

Top module: `fault_insert_cell`

## Requirements
- R1: With the fault enable at 0, the combinational models drive `net_out` equal to `net_in` in the same cycle, and the upset model loads `net_in` unchanged at every clock edge.
- R2: Stuck-at-0 (model 00): while the enable is 1, every bit whose `bit_sel` bit is 1 reads 0 on `net_out` in the same cycle, and every other bit follows `net_in`.
- R3: Stuck-at-1 (model 01): while the enable is 1, every selected bit reads 1, and every other bit follows `net_in`.
- R4: Transient (model 10): while the enable is 1, each selected bit takes the same-position bit of the parameter `TRANS_VAL`. Every other bit follows `net_in`. The substitution ends in the cycle the enable drops.
- R5: Upset with inversion (model 11, direction 0): at a clock edge with the enable at 1 and reset at 0, each selected bit of the register loads the inverse of its `net_in` bit, and each unselected bit loads `net_in`.
- R6: Upset flip-to-0 (model 11, direction 1): at such an edge, each selected bit loads 0. Where `net_in` is already 0 the bit stays 0. Unselected bits load `net_in`.
- R7: Upset flip-to-1 (model 11, direction 2): at such an edge, each selected bit loads 1. Unselected bits load `net_in`.
- R8: Upset model: at a clock edge with `rst` at 1, the register becomes all zeros, whatever the values of the enable and `bit_sel`.
- R9: Upset model: the corruption is not sticky. At the first edge after the enable returns to 0, the register loads the true `net_in` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the upset model's register; unused by the other models |
| rst | input | 1 | Synchronous active-high reset of the upset model's register |
| net_in | input | WIDTH | Original net value, or the register's data input |
| fault_en | input | 1 | Fault enable: 1 activates the fault on the selected bits |
| bit_sel | input | WIDTH | Per-bit mask naming the bits that are faulted |
| net_out | output | WIDTH | Net value after fault insertion, or the register output |

## Verification
In the upset model, reset and fault injection can occur on the same clock edge. The bench provokes this by raising `rst` while the enable is high and every bit is selected. It then checks that the register reads all zeros one edge later, which shows that reset has priority. The bench also applies a release in the cycle right after a flip. The register must then show the true input, and the combinational models must return to transparent in the same cycle the enable falls.

// File: rtl/fic_pkg.sv
package fic_pkg;
  typedef enum logic [1:0] {
    FM_STUCK0    = 2'b00,
    FM_STUCK1    = 2'b01,
    FM_TRANSIENT = 2'b10,
    FM_UPSET     = 2'b11
  } fault_model_e;

  typedef enum logic [1:0] {
    UPSET_INVERT  = 2'b00,
    UPSET_TO_ZERO = 2'b01,
    UPSET_TO_ONE  = 2'b10
  } upset_dir_e;
endpackage

// File: rtl/fic_force_cell.sv
module fic_force_cell #(
  parameter int unsigned           WIDTH     = 8,
  parameter logic [WIDTH-1:0]      FORCE_VAL = '0
) (
  input  logic [WIDTH-1:0] net_in,
  input  logic             fault_en,
  input  logic [WIDTH-1:0] bit_sel,
  output logic [WIDTH-1:0] net_out
);
  logic [WIDTH-1:0] hit;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign hit[b]     = fault_en & bit_sel[b];
    assign net_out[b] = hit[b] ? FORCE_VAL[b] : net_in[b];
  end

  // r1_ : released cell is transparent
  always_comb begin
    if (!fault_en) a_r1_transparent: assert (net_out == net_in);
  end

  // r2_/r3_/r4_ : selected bits carry the forced pattern, others pass
  always_comb begin
    if (fault_en) begin
      a_r4_forced_bits: assert ((net_out & bit_sel) == (FORCE_VAL & bit_sel));
      a_r4_other_bits:  assert ((net_out & ~bit_sel) == (net_in & ~bit_sel));
    end
  end
endmodule

// File: rtl/fic_upset_cell.sv
module fic_upset_cell
  import fic_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter upset_dir_e  DIR   = UPSET_INVERT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  input  logic             fault_en,
  input  logic [WIDTH-1:0] bit_sel,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] d_bad;
  logic [WIDTH-1:0] d_mux;

  assign hit = bit_sel & {WIDTH{fault_en}};

  if (DIR == UPSET_TO_ZERO) begin : g_to_zero
    assign d_bad = '0;
  end else if (DIR == UPSET_TO_ONE) begin : g_to_one
    assign d_bad = '1;
  end else begin : g_invert
    assign d_bad = ~d_in;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_mux
    assign d_mux[b] = hit[b] ? d_bad[b] : d_in[b];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d_mux;
  end

  // R8: reset clears the register, fault or not
  a_r8_reset_clears: assert property (@(posedge clk) rst |=> (q == '0));

  // R1 / R9: with no fault the true input is captured
  a_r9_clean_load: assert property (@(posedge clk) disable iff (rst)
    !fault_en |=> (q == $past(d_in)));

  // unselected bits always load the true input
  a_r5_unselected: assert property (@(posedge clk) disable iff (rst)
    fault_en |=> ((q & ~$past(bit_sel)) == ($past(d_in) & ~$past(bit_sel))));

  if (DIR == UPSET_TO_ZERO) begin : g_chk_zero
    a_r6_to_zero: assert property (@(posedge clk) disable iff (rst)
      fault_en |=> ((q & $past(bit_sel)) == '0));
  end else if (DIR == UPSET_TO_ONE) begin : g_chk_one
    a_r7_to_one: assert property (@(posedge clk) disable iff (rst)
      fault_en |=> ((q & $past(bit_sel)) == $past(bit_sel)));
  end else begin : g_chk_inv
    a_r5_inverted: assert property (@(posedge clk) disable iff (rst)
      fault_en |=> ((q & $past(bit_sel)) == (~$past(d_in) & $past(bit_sel))));
  end
endmodule

// File: rtl/fault_insert_cell.sv
module fault_insert_cell
  import fic_pkg::*;
#(
  parameter int unsigned      WIDTH     = 8,
  parameter fault_model_e     MODEL     = FM_STUCK0,
  parameter logic [WIDTH-1:0] TRANS_VAL = '0,
  parameter upset_dir_e       DIR       = UPSET_INVERT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] net_in,
  input  logic             fault_en,
  input  logic [WIDTH-1:0] bit_sel,
  output logic [WIDTH-1:0] net_out
);
  localparam logic [WIDTH-1:0] FORCE_PAT =
    (MODEL == FM_STUCK1)    ? {WIDTH{1'b1}} :
    (MODEL == FM_TRANSIENT) ? TRANS_VAL     : {WIDTH{1'b0}};

  if (MODEL == FM_UPSET) begin : g_upset
    fic_upset_cell #(
      .WIDTH (WIDTH),
      .DIR   (DIR)
    ) i_upset (
      .clk      (clk),
      .rst      (rst),
      .d_in     (net_in),
      .fault_en (fault_en),
      .bit_sel  (bit_sel),
      .q        (net_out)
    );
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    fic_force_cell #(
      .WIDTH     (WIDTH),
      .FORCE_VAL (FORCE_PAT)
    ) i_force (
      .net_in   (net_in),
      .fault_en (fault_en),
      .bit_sel  (bit_sel),
      .net_out  (net_out)
    );
  end
endmodule

// File: tb/test_fault_insert_cell.sv
module test_fault_insert_cell;
  import fic_pkg::*;
  localparam int W = 8;
  localparam logic [W-1:0] TV = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] din = '0;
  logic fen = 1'b0;
  logic [W-1:0] sel = '0;
  logic [W-1:0] o_s0, o_s1, o_tr, o_inv, o_z, o_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fault_insert_cell #(.WIDTH(W), .MODEL(FM_STUCK0)) i_fault_insert_cell (
    .clk(clk), .rst(rst), .net_in(din), .fault_en(fen), .bit_sel(sel), .net_out(o_s0));
  fault_insert_cell #(.WIDTH(W), .MODEL(FM_STUCK1)) i_s1 (
    .clk(clk), .rst(rst), .net_in(din), .fault_en(fen), .bit_sel(sel), .net_out(o_s1));
  fault_insert_cell #(.WIDTH(W), .MODEL(FM_TRANSIENT), .TRANS_VAL(TV)) i_tr (
    .clk(clk), .rst(rst), .net_in(din), .fault_en(fen), .bit_sel(sel), .net_out(o_tr));
  fault_insert_cell #(.WIDTH(W), .MODEL(FM_UPSET), .DIR(UPSET_INVERT)) i_inv (
    .clk(clk), .rst(rst), .net_in(din), .fault_en(fen), .bit_sel(sel), .net_out(o_inv));
  fault_insert_cell #(.WIDTH(W), .MODEL(FM_UPSET), .DIR(UPSET_TO_ZERO)) i_z (
    .clk(clk), .rst(rst), .net_in(din), .fault_en(fen), .bit_sel(sel), .net_out(o_z));
  fault_insert_cell #(.WIDTH(W), .MODEL(FM_UPSET), .DIR(UPSET_TO_ONE)) i_o (
    .clk(clk), .rst(rst), .net_in(din), .fault_en(fen), .bit_sel(sel), .net_out(o_o));

  // vector fields: {fault_en, bit_sel, net_in}
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'h3C},
    {1'b1, 8'h01, 8'h3C},
    {1'b1, 8'h04, 8'h3C},
    {1'b1, 8'h80, 8'hFF},
    {1'b1, 8'h80, 8'h00},
    {1'b0, 8'hFF, 8'h5A},
    {1'b1, 8'h10, 8'h5A},
    {1'b1, 8'h02, 8'h00}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic [W-1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    fen = f; sel = s; din = d;
  endtask

  task automatic check_comb(input logic f, input logic [W-1:0] s, input logic [W-1:0] d);
    logic [W-1:0] m;
    m = f ? s : '0;
    #0.5;
    check(f ? "R2 stuck0" : "R1 stuck0 clear", o_s0, d & ~m);
    check(f ? "R3 stuck1" : "R1 stuck1 clear", o_s1, d | m);
    check(f ? "R4 transient" : "R1 transient clear", o_tr, (d & ~m) | (TV & m));
  endtask

  task automatic check_regs(input logic f, input logic [W-1:0] s, input logic [W-1:0] d);
    logic [W-1:0] m;
    m = f ? s : '0;
    @(posedge clk);
    #1;
    check(f ? "R5 upset invert" : "R1 upset load", o_inv, d ^ m);
    check(f ? "R6 upset to0"    : "R1 upset load", o_z, d & ~m);
    check(f ? "R7 upset to1"    : "R1 upset load", o_o, d | m);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (2) @(posedge clk);
    #1;
    check("R8 reset inv", o_inv, '0);
    check("R8 reset to0", o_z, '0);
    check("R8 reset to1", o_o, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
      check_comb(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
      check_regs(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R6 corner: selected bit already 0 stays 0
    drive(1'b1, 8'h01, 8'hF0);
    check_regs(1'b1, 8'h01, 8'hF0);

    // multi-bit mask across all models
    drive(1'b1, 8'hC3, 8'h96);
    check_comb(1'b1, 8'hC3, 8'h96);
    check_regs(1'b1, 8'hC3, 8'h96);

    // R9: release right after a flip, true data returns
    drive(1'b0, 8'hC3, 8'h96);
    check_comb(1'b0, 8'hC3, 8'h96);
    #0.5;
    check("R9 release inv", o_inv, 8'h96 ^ 8'hC3);
    check_regs(1'b0, 8'hC3, 8'h96);
    check("R9 release to1", o_o, 8'h96);

    // R8: reset and full injection on the same edge, reset wins
    drive(1'b1, 8'hFF, 8'h55);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R8 reset over fault inv", o_inv, '0);
    check("R8 reset over fault to0", o_z, '0);
    check("R8 reset over fault to1", o_o, '0);
    check("R2 stuck0 during reset", o_s0, '0);
    @(negedge clk);
    rst = 1'b0;
    check_regs(1'b1, 8'hFF, 8'h55);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule